// File: doc/BRIEF.md
# Addressable Tap Delay Shift Register

This block is a serial bit delay line with sixteen stages. One bit enters per enabled clock edge. A 4-bit tap address picks which stage drives the tapped output, so the delay can be changed from one cycle to the next anywhere between 1 and 16 enabled clocks. It is meant for balancing the latency of datapath branches in a pipeline, where the amount of delay needed is only known at run time.

The last stage is always visible on a separate cascade output, whatever the tap address. Feeding that output into the serial input of a second instance builds a longer delay line. A build-time parameter adds an output flip-flop after the tap selector. That flip-flop uses the same clock enable and adds exactly one more enabled cycle of delay.

Top module: `tap_delay_line`

## Requirements
- R1: While reset (`rst_n` low) is asserted, every stage is cleared. After reset, both `tap_out` and `cascade_out` read 0 until a 1 has been shifted far enough to reach them.
- R2: On each rising clock edge with `shift_en` high, `ser_in` is captured into the first stage and every other stage takes the value of the stage before it.
- R3: With no output register and `tap_sel` equal to k (0 to 15), `tap_out` equals the `ser_in` bit captured k+1 enabled edges earlier. Address 0 gives a delay of 1 and address 15 gives a delay of 16.
- R4: `cascade_out` equals the `ser_in` bit captured 16 enabled edges earlier, for any value of `tap_sel`.
- R5: On an edge with `shift_en` low, every stage keeps its value, so neither output changes while the tap address is held.
- R6: A change of `tap_sel` shows on `tap_out` within the same clock cycle, with no clock edge in between.
- R7: With the output register enabled (`OUT_REG`=1), `tap_out` loads the selected stage on each enabled edge and holds otherwise. The total delay is k+2 enabled edges.
- R8: Connecting `cascade_out` of one instance to `ser_in` of a second instance that has the same enable gives a delay of 16 plus the second instance's own delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Clock enable for shifting |
| ser_in | input | 1 | Serial data input |
| tap_sel | input | 4 | Tap address; a value of k selects stage k+1 |
| tap_out | output | 1 | Tapped output, optionally registered |
| cascade_out | output | 1 | Last-stage output, used for chaining |

## Verification
The stage contents move one step on the enabled edge itself. `cascade_out` is therefore due directly after the 16th enabled edge following the input bit, and unregistered `tap_out` directly after the (k+1)th. The registered variant is due one enabled edge later. A change of address is due in the same cycle, before any edge. The bench drives inputs on the falling edge and updates its history model at the rising edge. It samples outputs a few nanoseconds after the rising edge, and it checks address changes a few nanoseconds after driving them with no edge in between. Disabled cycles leave the model untouched, which checks the hold rule.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int unsigned TDL_MAX_DEPTH = 64;

  // one-hot stage select for a tap address
  function automatic logic [TDL_MAX_DEPTH-1:0] tap_onehot(input int unsigned sel);
    logic [TDL_MAX_DEPTH-1:0] v;
    v = '0;
    v[sel] = 1'b1;
    return v;
  endfunction

  // delay in enabled cycles for an address and output register option
  function automatic int unsigned tap_latency(input int unsigned sel, input bit out_reg);
    return sel + 1 + (out_reg ? 1 : 0);
  endfunction
endpackage

// File: rtl/tdl_shift_core.sv
module tdl_shift_core #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [DEPTH-1:0] stage_q
);
  logic shift_fire;
  assign shift_fire = shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stage_q <= '0;
    else if (shift_fire) stage_q <= {stage_q[DEPTH-2:0], ser_in};
  end

  // R2: entry stage takes the serial bit
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> stage_q[0] == $past(ser_in));
  // R2: every later stage takes its predecessor
  p_shift_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> stage_q[DEPTH-1:1] == $past(stage_q[DEPTH-2:0]));
  // R5: disabled edge holds all stages
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> $stable(stage_q));
endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux
  import tdl_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [DEPTH-1:0]  stage_q,
  input  logic [ADDR_W-1:0] tap_sel,
  output logic              tap_bit
);
  logic [TDL_MAX_DEPTH-1:0] sel_full;
  logic [DEPTH-1:0]         sel_hot;
  logic [DEPTH-1:0]         picked;

  always_comb sel_full = tap_onehot(int'(tap_sel));
  assign sel_hot = sel_full[DEPTH-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_pick
    assign picked[g] = stage_q[g] & sel_hot[g];
  end

  assign tap_bit = |picked;
endmodule

// File: rtl/tdl_out_stage.sv
module tdl_out_stage #(
  parameter bit OUT_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic d,
  output logic q
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (shift_en) q <= d;
    end
    // R7: register loads the selected bit on an enabled edge
    p_reg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> q == $past(d));
    // R7: register holds while disabled
    p_reg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(q));
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import tdl_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic [ADDR_W-1:0] tap_sel,
  output logic              tap_out,
  output logic              cascade_out
);
  localparam int unsigned MAX_DELAY = tap_latency(DEPTH - 1, OUT_REG);

  logic [DEPTH-1:0] stage_q;
  logic             tap_bit;

  initial begin
    if (DEPTH < 2 || DEPTH > TDL_MAX_DEPTH || MAX_DELAY != DEPTH + (OUT_REG ? 1 : 0))
      $error("tap_delay_line: unsupported DEPTH");
  end

  tdl_shift_core #(.DEPTH(DEPTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .stage_q  (stage_q)
  );

  tdl_tap_mux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mux (
    .stage_q (stage_q),
    .tap_sel (tap_sel),
    .tap_bit (tap_bit)
  );

  tdl_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .d        (tap_bit),
    .q        (tap_out)
  );

  assign cascade_out = stage_q[DEPTH-1];

  // R4: cascade output moves one stage per enabled edge
  p_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cascade_out == $past(stage_q[DEPTH-2]));
  // R5: cascade output steady while disabled
  p_cascade_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cascade_out));
endmodule

// File: tb/tap_delay_line_tb.sv
module tap_delay_line_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       ser_in = 1'b0;
  logic [3:0] tap_a = 4'd0;
  logic [3:0] tap_b = 4'd0;
  logic       tap_out_a, casc_a, tap_out_b, casc_b;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  logic [63:0] hist = '0;   // hist[0] = newest shifted bit
  logic        exp_q_b = 1'b0;

  always #10 clk = ~clk;    // 50 MHz

  tap_delay_line #(.DEPTH(16), .OUT_REG(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .tap_sel(tap_a), .tap_out(tap_out_a), .cascade_out(casc_a));

  tap_delay_line #(.DEPTH(16), .OUT_REG(1'b1)) casc_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(casc_a),
    .tap_sel(tap_b), .tap_out(tap_out_b), .cascade_out(casc_b));

  function automatic logic exp_tap(input logic [63:0] h, input int unsigned k);
    return h[k];   // delay k+1 -> index k
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 tap delay", tap_out_a, exp_tap(hist, tap_a));
    chk("R4 cascade", casc_a, hist[15]);
    chk("R7/R8 registered cascade tap", tap_out_b, exp_q_b);
    chk("R8 chained last stage", casc_b, hist[31]);
  endtask

  task automatic step(input logic d, input logic en, input logic [3:0] ka, input logic [3:0] kb);
    @(negedge clk);
    ser_in = d; shift_en = en; tap_a = ka; tap_b = kb;
    @(posedge clk);
    if (en) begin
      exp_q_b = hist[16 + kb];
      hist = {hist[62:0], d};
    end
    #5;
    check_all();
  endtask

  initial begin : watchdog
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] snap;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #3;
    // R1: reset state
    chk("R1 reset tap", tap_out_a, 1'b0);
    chk("R1 reset cascade", casc_a, 1'b0);
    chk("R1 reset registered tap", tap_out_b, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R2/R3: single 1 travels, tap 0 sees it after one enabled edge
    step(1'b1, 1'b1, 4'd0, 4'd0);
    chk("R2 R3 first stage", tap_out_a, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 4'd15, 4'd0);
    // R3/R4: after 16 enabled edges the bit sits at tap 15 and cascade
    chk("R3 tap 15 delay 16", tap_out_a, 1'b1);
    chk("R4 cascade delay 16", casc_a, 1'b1);

    // R5: disabled edges hold everything
    snap = hist;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 4'd15, 4'd3);
    chk("R5 hold tap", tap_out_a, snap[15]);
    chk("R5 hold cascade", casc_a, snap[15]);

    // R6: address change visible within the same cycle
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      shift_en = 1'b0;
      tap_a = 4'(k);
      #2;
      chk("R6 same-cycle tap change", tap_out_a, hist[k]);
    end

    // random mix: enable, data and both addresses
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), ($urandom % 4) != 0, 4'($urandom), 4'($urandom));
    end

    // R7/R8: directed registered tail at address 15 of second stage
    for (int i = 0; i < 40; i++) step(1'(i == 0), 1'b1, 4'd0, 4'd15);
    chk("R8 total delay 33 done", tap_out_b, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule